// File: doc/BRIEF.md
# Multiword DMA Device Burst Responder

This block is the device end of a parallel multiword DMA link. The host loads a command with a word count and a direction. The block then raises its request line whenever the local buffer holds enough data, or has enough free space, to be worth a burst. While the host acknowledges, the block answers each read strobe by presenting buffer data and turning on the data bus drivers. It captures the bus word of each write strobe and pushes it into the buffer.

The host strobes and the acknowledge arrive with no relation to the device clock. Each passes through a two-flop synchronizer, and edges are taken from the synchronized copies. To pause, the device drops its request while a strobe is active. That strobe still moves its word and is the last one of the burst. The device pauses when the buffer level it reports is at or just above a configured threshold, or when the strobe carries the last word of the command.

A later burst follows when the host has released the acknowledge and the buffer has recovered. If the host ends a burst on its own, the request stays high and the device waits. When the count reaches zero the request stays low and a completion flag is set.

Top module: `mdma_dev_responder`

## Requirements
- R1: After reset, dmarq_o, dd_oe_o, done_o, rd_pop_o and wr_push_o are all 0.
- R2: After cmd_start_i with a nonzero count, dmarq_o rises within 4 cycles if room_i > PAUSE_THR and dmack_ni is high.
- R3: With cmd_dir_i = 1 (device to host), dd_oe_o is 1 while the synchronized acknowledge is active. dd_o shows the current buffer head. Each dior_ni rising edge during acknowledge gives exactly one rd_pop_o pulse. rd_pop_o and wr_push_o are never both 1.
- R4: With cmd_dir_i = 0 (host to device), each diow_ni rising edge during acknowledge gives one wr_push_o pulse. wr_data_o then holds the dd_i value driven during that strobe.
- R5: If room_i <= PAUSE_THR+1 when a strobe is asserted during a burst, dmarq_o is 0 before that strobe ends, and that strobe's word is still transferred.
- R6: A strobe that carries the last word of the command drops dmarq_o. After it, done_o is 1 and dmarq_o stays 0 until the next command.
- R7: After a pause, dmarq_o stays 0 while room_i <= PAUSE_THR. Once dmack_ni is high and room_i > PAUSE_THR with words left, dmarq_o rises again.
- R8: If the host negates dmack_ni while dmarq_o is high, dmarq_o stays high. dd_oe_o is 0 within 3 cycles of the dmack_ni rise.
- R9: Strobes while dmack_ni is high move no word and leave the remaining count unchanged.
- R10: cmd_start_i with a zero count sets done_o and never raises dmarq_o. A new command clears done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_start_i | input | 1 | One-cycle pulse that loads a command |
| cmd_words_i | input | CNT_W | Words in the command |
| cmd_dir_i | input | 1 | 1 = device to host, 0 = host to device |
| room_i | input | LVL_W | Buffer words ready (read) or free (write) |
| rd_data_i | input | DATA_W | Head word of the read buffer |
| rd_pop_o | output | 1 | Head word consumed |
| wr_data_o | output | DATA_W | Captured write word |
| wr_push_o | output | 1 | wr_data_o is a new word |
| dmarq_o | output | 1 | DMA request to host |
| dmack_ni | input | 1 | Host acknowledge, active low, asynchronous |
| dior_ni | input | 1 | Host read strobe, active low, asynchronous |
| diow_ni | input | 1 | Host write strobe, active low, asynchronous |
| dd_i | input | DATA_W | Bus data from host |
| dd_o | output | DATA_W | Bus data to host |
| dd_oe_o | output | 1 | Bus driver enable |
| done_o | output | 1 | Command complete |

## Verification
The bench builds the block with an 8-bit count, a 6-bit buffer level and a pause threshold of 2. With these values a buffer refill of only a few words is enough to force a pause. Commands of up to 24 words therefore pass through several pause and resume cycles, as well as final-word stops and host-ended bursts. Random directions and refill levels mix pauses caused by the buffer level with stops at the end of a command.

// File: rtl/mdma_resp_pkg.sv
package mdma_resp_pkg;
  typedef enum logic {
    DIR_TO_DEV  = 1'b0,
    DIR_TO_HOST = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/mdma_resp_sync.sv
module mdma_resp_sync #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] s1_o,
  output logic [N-1:0] s2_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q1, q2, q3;
    // inactive-high lines reset to 1
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q1 <= 1'b1;
        q2 <= 1'b1;
        q3 <= 1'b1;
      end else begin
        q1 <= async_i[i];
        q2 <= q1;
        q3 <= q2;
      end
    end
    assign s1_o[i]   = q1;
    assign s2_o[i]   = q2;
    assign rise_o[i] = q2 & ~q3;
    assign fall_o[i] = ~q2 & q3;
  end
endmodule

// File: rtl/mdma_resp_ctrl.sv
module mdma_resp_ctrl
  import mdma_resp_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int LVL_W     = 8,
  parameter int PAUSE_THR = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] words_i,
  input  xfer_dir_e        dir_i,
  input  logic [LVL_W-1:0] room_i,
  input  logic             ack_i,
  input  logic             stb_on_i,
  input  logic             stb_asrt_i,
  input  logic             stb_rel_i,
  output logic             req_o,
  output logic             done_o,
  output xfer_dir_e        dir_o,
  output logic             xfer_o
);
  localparam logic [LVL_W-1:0] THR_LVL  = LVL_W'(PAUSE_THR);
  localparam logic [LVL_W-1:0] PAUSE_AT = LVL_W'(PAUSE_THR + 1);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             req_q, done_q;
  xfer_dir_e        dir_q;
  logic             last_word, low_room;

  assign last_word = (cnt_q == ONE);
  assign low_room  = (room_i <= PAUSE_AT);
  assign xfer_o    = ack_i & stb_rel_i & (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      req_q  <= 1'b0;
      done_q <= 1'b0;
      dir_q  <= DIR_TO_DEV;
    end else if (start_i) begin
      cnt_q  <= words_i;
      done_q <= (words_i == '0);
      req_q  <= 1'b0;
      dir_q  <= dir_i;
    end else begin
      if (xfer_o) begin
        cnt_q <= cnt_q - ONE;
        if (last_word) done_q <= 1'b1;
      end
      if (req_q) begin
        // drop during the strobe: this strobe carries the burst's final word
        if (ack_i && stb_asrt_i && (last_word || low_room)) req_q <= 1'b0;
      end else if (!done_q && cnt_q != '0 && !ack_i && !stb_on_i && room_i > THR_LVL) begin
        req_q <= 1'b1;
      end
    end
  end

  assign req_o  = req_q;
  assign done_o = done_q;
  assign dir_o  = dir_q;

  assert_done_blocks_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !req_q);
  assert_pause_on_low_room_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && ack_i && stb_asrt_i && low_room && !start_i) |=> !req_q);
  assert_req_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !stb_asrt_i && !start_i) |=> req_q);
  assert_no_count_without_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_i && !start_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/mdma_resp_datapath.sv
module mdma_resp_datapath
  import mdma_resp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_i,
  input  xfer_dir_e         dir_i,
  input  logic              xfer_i,
  input  logic              wr_early_on_i,
  input  logic [DATA_W-1:0] dd_i,
  output logic              dd_oe_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_push_o,
  output logic              rd_pop_o
);
  logic              oe_q;
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q   <= 1'b0;
      hold_q <= '0;
    end else begin
      oe_q <= ack_i & (dir_i == DIR_TO_HOST);
      // first sync stage still sees the strobe: bus is inside its valid window
      if (wr_early_on_i) hold_q <= dd_i;
    end
  end

  assign dd_oe_o   = oe_q;
  assign wr_data_o = hold_q;
  assign wr_push_o = xfer_i & (dir_i == DIR_TO_DEV);
  assign rd_pop_o  = xfer_i & (dir_i == DIR_TO_HOST);

  assert_release_after_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> !oe_q);
  assert_pop_push_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_push_o && rd_pop_o));
  assert_no_move_without_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |-> !(wr_push_o || rd_pop_o));
endmodule

// File: rtl/mdma_dev_responder.sv
module mdma_dev_responder
  import mdma_resp_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 16,
  parameter int LVL_W     = 8,
  parameter int PAUSE_THR = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_start_i,
  input  logic [CNT_W-1:0]  cmd_words_i,
  input  logic              cmd_dir_i,
  input  logic [LVL_W-1:0]  room_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_pop_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_push_o,
  output logic              dmarq_o,
  input  logic              dmack_ni,
  input  logic              dior_ni,
  input  logic              diow_ni,
  input  logic [DATA_W-1:0] dd_i,
  output logic [DATA_W-1:0] dd_o,
  output logic              dd_oe_o,
  output logic              done_o
);
  localparam int ACK = 0;
  localparam int RD  = 1;
  localparam int WR  = 2;

  logic [2:0] s1, s2, rise, fall;
  logic       ack, stb_on, stb_asrt, stb_rel, xfer;
  xfer_dir_e  dir;

  mdma_resp_sync #(.N(3)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({diow_ni, dior_ni, dmack_ni}),
    .s1_o    (s1),
    .s2_o    (s2),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  assign ack      = ~s2[ACK];
  assign stb_on   = (dir == DIR_TO_HOST) ? ~s2[RD]  : ~s2[WR];
  assign stb_asrt = (dir == DIR_TO_HOST) ? fall[RD] : fall[WR];
  assign stb_rel  = (dir == DIR_TO_HOST) ? rise[RD] : rise[WR];

  mdma_resp_ctrl #(
    .CNT_W(CNT_W), .LVL_W(LVL_W), .PAUSE_THR(PAUSE_THR)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (cmd_start_i),
    .words_i    (cmd_words_i),
    .dir_i      (xfer_dir_e'(cmd_dir_i)),
    .room_i     (room_i),
    .ack_i      (ack),
    .stb_on_i   (stb_on),
    .stb_asrt_i (stb_asrt),
    .stb_rel_i  (stb_rel),
    .req_o      (dmarq_o),
    .done_o     (done_o),
    .dir_o      (dir),
    .xfer_o     (xfer)
  );

  mdma_resp_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ack_i         (ack),
    .dir_i         (dir),
    .xfer_i        (xfer),
    .wr_early_on_i (~s1[WR]),
    .dd_i          (dd_i),
    .dd_oe_o       (dd_oe_o),
    .wr_data_o     (wr_data_o),
    .wr_push_o     (wr_push_o),
    .rd_pop_o      (rd_pop_o)
  );

  assign dd_o = rd_data_i;
endmodule

// File: tb/sim_mdma_dev_responder.sv
module sim_mdma_dev_responder;
  localparam int DW = 16, CW = 8, LW = 6, THR = 2;

  logic clk = 0, rst_n = 0;
  logic cmd_start = 0, cmd_dir = 0;
  logic [CW-1:0] cmd_words = 0;
  logic [LW-1:0] room_i;
  logic [DW-1:0] rd_data, wr_data, dd_i = 0, dd_o;
  logic rd_pop, wr_push, dmarq, dd_oe, done;
  logic dmack_n = 1, dior_n = 1, diow_n = 1;

  int checks = 0, errors = 0;
  int room = 0, rem = 0;
  int rd_ptr = 0, rd_exp = 0, pops = 0, pushes = 0, exp_pops = 0, exp_pushes = 0;
  logic [DW-1:0] src [256];
  logic [DW-1:0] wexp [1024];
  int wexp_wr = 0;

  always #4 clk = ~clk;
  assign room_i  = room[LW-1:0];
  assign rd_data = src[rd_ptr % 256];

  mdma_dev_responder #(.DATA_W(DW), .CNT_W(CW), .LVL_W(LW), .PAUSE_THR(THR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_start_i(cmd_start), .cmd_words_i(cmd_words),
    .cmd_dir_i(cmd_dir), .room_i(room_i), .rd_data_i(rd_data), .rd_pop_o(rd_pop),
    .wr_data_o(wr_data), .wr_push_o(wr_push), .dmarq_o(dmarq), .dmack_ni(dmack_n),
    .dior_ni(dior_n), .diow_ni(diow_n), .dd_i(dd_i), .dd_o(dd_o), .dd_oe_o(dd_oe),
    .done_o(done));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit burst_ends(input int r, input int lvl);
    return (r == 1) || (lvl <= THR + 1);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // buffer and word monitor
  always @(negedge clk) begin
    if (rd_pop) begin pops++; rd_ptr++; end
    if (wr_push) begin
      checks++;
      if (wr_data !== wexp[pushes % 1024]) begin
        errors++;
        $display("FAIL R4: actual %0h expected %0h", wr_data, wexp[pushes % 1024]);
      end
      pushes++;
    end
  end

  task automatic start_cmd(input int words, input bit dir);
    @(posedge clk); #2;
    cmd_start = 1; cmd_words = CW'(words); cmd_dir = dir;
    cyc(1);
    cmd_start = 0;
    rem = words;
  endtask

  task automatic host_burst(input int max_stb, input bit dir, output bit stopped);
    int n = 0;
    bit last;
    stopped = 0;
    dmack_n = 0;
    cyc(3);
    while (n < max_stb) begin
      last = burst_ends(rem, room);
      if (!dir) begin
        dd_i = DW'($urandom);
        wexp[wexp_wr % 1024] = dd_i;
        wexp_wr++;
        diow_n = 0;
      end else dior_n = 0;
      cyc(6);
      @(negedge clk);
      if (rem == 1) chk("R6", dmarq, 0);
      else chk("R5", dmarq, !last);
      if (dir) begin
        chk("R3", dd_oe, 1);
        chk("R3", dd_o, src[rd_exp % 256]);
        rd_exp++;
      end
      cyc(1);
      dior_n = 1; diow_n = 1;
      rem--; room--; n++;
      if (dir) exp_pops++; else exp_pushes++;
      cyc(6);
      if (last) begin stopped = 1; break; end
    end
    cyc(2);
    dmack_n = 1;
    cyc(3);
    @(negedge clk);
    chk("R8", dd_oe, 0);
    cyc(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit stopped;
    int waitc;
    void'($urandom(32'd7321));
    for (int i = 0; i < 256; i++) src[i] = DW'($urandom);
    cyc(3);
    @(negedge clk);
    chk("R1", {dmarq, dd_oe, done, rd_pop, wr_push}, 0);
    rst_n = 1;
    cyc(2);

    // R10: zero-word command
    start_cmd(0, 1);
    cyc(3); @(negedge clk);
    chk("R10", done, 1);
    chk("R10", dmarq, 0);

    for (int c = 0; c < 14; c++) begin
      bit dir = (c < 2) ? bit'(c) : bit'($urandom % 2);
      int words = (c == 2) ? 1 : 1 + int'($urandom % 24);
      room = (c < 2) ? 1 : int'($urandom % 12);
      start_cmd(words, dir);
      @(negedge clk);
      chk("R10", done, 0);
      if (c < 2) begin
        // R9: strobes with no acknowledge move nothing
        for (int k = 0; k < 3; k++) begin
          dior_n = 0; diow_n = 0; dd_i = 16'hdead; cyc(5);
          dior_n = 1; diow_n = 1; cyc(5);
        end
        @(negedge clk);
        chk("R9", pops, exp_pops);
        chk("R9", pushes, exp_pushes);
      end
      while (rem > 0) begin
        if (room <= THR) begin
          cyc(6); @(negedge clk);
          chk("R7", dmarq, 0);
          room = THR + 1 + int'($urandom % 8);
        end
        waitc = 0;
        while (!dmarq && waitc < 12) begin cyc(1); waitc++; end
        @(negedge clk);
        chk("R2", dmarq, 1);
        host_burst(($urandom % 4 == 0) ? 1 + int'($urandom % 3) : 100, dir, stopped);
        @(negedge clk);
        if (!stopped) chk("R8", dmarq, 1);
        else if (rem > 0 && room > THR) begin
          cyc(5); @(negedge clk);
          chk("R7", dmarq, 1);
        end
      end
      cyc(4); @(negedge clk);
      chk("R6", done, 1);
      chk("R6", dmarq, 0);
      chk("R3", pops, exp_pops);
      chk("R4", pushes, exp_pushes);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule